// File: doc/BRIEF.md
# Professional/Consumer Digital Audio Subframe Transmitter

This block turns a stream of parallel audio samples into a self-clocking serial line signal for a two-channel digital audio link. Each sample arrives with its validity, user and channel status bits. The block places the sample into a subframe, adds a sync preamble and an even parity bit, and sends the result as a biphase-mark coded differential pair. One half-cell goes out per master clock, so a frame of two subframes takes 128 clocks.

Frames are counted in blocks of 192. Frame 0 opens with a distinct preamble. A block strobe marks the first 128 frames. In professional mode the last channel status byte can be replaced by a CRC. The CRC is computed over the channel status bits already sent in that block, separately for each channel. The data source holds a sample ready and watches an acknowledge pulse. On that pulse it moves on to the next sample.

Top module: `aes3_tx`

## Requirements
- R1: A clock edge at which rst is high drives tx_p, tx_n, blk_strobe and smp_ack low. It returns the position to frame 0, left subframe, half-cell 0, and the reference line level for the next preamble becomes 0.
- R2: A subframe has 32 bit slots. Slots 0 to 3 are the preamble. Slot 4+i carries smp_data bit i for i = 0 to 23, so the LSB goes first. Slot 28 is V, slot 29 is U and slot 30 is C. Slot 31 is a parity bit that makes the count of ones in slots 4 to 31 even.
- R3: Each slot from 4 to 31 is sent as two half-cells of one clock each. The line inverts at the start of every slot. It inverts again between the two halves when the slot bit is 1.
- R4: A preamble is 8 half-cells. Each half-cell is the listed pattern bit (MSB first) XOR the level of the last half-cell before it. X = 11100010 is used on left subframes other than frame 0, and Y = 11100100 on every right subframe.
- R5: A block is 192 frames, each a left then a right subframe. The left subframe of frame 0 uses Z = 11101000, and this includes the first subframe after reset.
- R6: The inputs smp_data, smp_v, smp_u, smp_c, smp_rdy, pro_mode and crc_en are sampled on the edge that emits half-cell 0 of a subframe. smp_ack is high for exactly the following clock. If smp_rdy is low at that edge, the subframe carries a zero sample with V=1, U=0 and C=0.
- R7: In frames 184+k (k = 0 to 7), when pro_mode and crc_en are both high, slot 30 carries bit k of a CRC register kept for that channel. The register is set to 0xFF and then stepped at frame 0. It is stepped with each C bit sent in frames 0 to 183, using fb = c XOR r[7] and r = (r << 1) XOR (fb ? 0x1D : 0).
- R8: When pro_mode or crc_en is low, slot 30 in frames 184 to 191 carries smp_c unchanged.
- R9: Let p be the index of the half-cell currently shown, counted from frame 0. blk_strobe shows ((p+2) mod 24576) < 16384. So it rises one bit period (2 clocks) before frame 0 and falls one bit period before frame 128, with the same latency as the line.
- R10: The first edge with rst low emits half-cell 0 of frame 0 left. After that, exactly one half-cell is emitted per clock. Outside reset, tx_n is always the complement of tx_p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, one half-cell per period |
| rst | input | 1 | Synchronous active-high reset |
| smp_data | input | 24 | Sample bits including auxiliary bits, bit 0 sent first |
| smp_v | input | 1 | Validity bit for the subframe |
| smp_u | input | 1 | User bit for the subframe |
| smp_c | input | 1 | Channel status bit for the subframe |
| smp_rdy | input | 1 | Source has a sample ready |
| pro_mode | input | 1 | Professional channel status format |
| crc_en | input | 1 | Allow CRC insertion in professional mode |
| smp_ack | output | 1 | One-clock pulse: inputs were taken |
| tx_p | output | 1 | Positive line drive |
| tx_n | output | 1 | Negative line drive |
| blk_strobe | output | 1 | High across channel status bytes 0 to 15 |

## Verification
The sample stream mixes a shifting pseudo-random pattern with all-ones, all-zeros and alternating words. All-ones words make every cell toggle mid-cell, so an error in the second half-cell shows up. All-zeros words isolate the cell-boundary toggles and the preamble polarity. The stream runs for more than two blocks: the first in professional mode with CRC, the second in consumer mode, the third with CRC disabled. Comparing these blocks separates CRC insertion from C-bit passthrough, and the Z preamble repeats at each block. Occasional missing samples exercise the underrun substitution. A reset in the middle of a frame checks that the outputs go quiet and that the stream restarts at a Z preamble from level 0.

// File: rtl/aes3_pkg.sv
package aes3_pkg;
  // preamble half-cell patterns, MSB first, relative to the previous line level
  localparam logic [7:0] PRE_Z = 8'b11101000;
  localparam logic [7:0] PRE_Y = 8'b11100100;
  localparam logic [7:0] PRE_X = 8'b11100010;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_INIT = 8'hFF;

  typedef enum logic [1:0] {PRE_KIND_Z, PRE_KIND_X, PRE_KIND_Y} pre_kind_e;

  function automatic logic [7:0] crc_step(input logic [7:0] r, input logic d);
    logic fb;
    fb = d ^ r[7];
    return {r[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
  endfunction
endpackage

// File: rtl/aes3_timing.sv
module aes3_timing #(
  parameter int FRAMES       = 192,
  parameter int HALVES       = 64,
  parameter int STROBE_FRAME = 128,
  parameter int HC_W         = $clog2(HALVES),
  parameter int FR_W         = $clog2(FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [HC_W-1:0] hc,
  output logic            sub,
  output logic [FR_W-1:0] frm,
  output logic            blk_q
);
  localparam int LEAD   = 2;              // one bit period in half-cells
  localparam int FRM_HC = 2 * HALVES;
  localparam int TOTAL  = FRAMES * FRM_HC;
  localparam int POS_W  = $clog2(TOTAL + LEAD) + 1;

  logic [POS_W-1:0] pos, pos_l;
  logic             blk_next;

  always_comb begin
    pos = POS_W'(frm) * POS_W'(FRM_HC) + (sub ? POS_W'(HALVES) : '0) + POS_W'(hc);
    pos_l = pos + POS_W'(LEAD);
    if (pos_l >= POS_W'(TOTAL)) pos_l = pos_l - POS_W'(TOTAL);
    blk_next = pos_l < POS_W'(STROBE_FRAME * FRM_HC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hc    <= '0;
      sub   <= 1'b0;
      frm   <= '0;
      blk_q <= 1'b0;
    end else begin
      blk_q <= blk_next;
      if (hc == HC_W'(HALVES - 1)) begin
        hc  <= '0;
        sub <= ~sub;
        if (sub) frm <= (frm == FR_W'(FRAMES - 1)) ? '0 : frm + 1'b1;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  a_r5_frame_range: assert property (@(posedge clk) disable iff (rst)
    frm < FR_W'(FRAMES));

  // R9: strobe drops one bit period ahead of the strobe frame
  a_r9_strobe_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(blk_q) |-> (frm == FR_W'(STROBE_FRAME - 1) && sub &&
                      hc == HC_W'(HALVES - LEAD + 1)));
endmodule

// File: rtl/aes3_crc.sv
module aes3_crc import aes3_pkg::*; #(
  parameter int FRAMES = 192,
  parameter int FR_W   = $clog2(FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            sub,
  input  logic [FR_W-1:0] frm,
  input  logic            c_in,
  output logic            crc_bit,
  output logic            in_tail
);
  localparam int TAIL = FRAMES - 8;

  logic [7:0]      crc_q [2];
  logic [FR_W-1:0] off;

  assign in_tail = frm >= FR_W'(TAIL);
  assign off     = frm - FR_W'(TAIL);
  assign crc_bit = crc_q[sub][off[2:0]];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        crc_q[ch] <= CRC_INIT;
      end else if (load && (sub == ch[0]) && !in_tail) begin
        crc_q[ch] <= crc_step((frm == '0) ? CRC_INIT : crc_q[ch], c_in);
      end
    end

    // R7: the CRC being sent stays frozen over the tail frames
    a_r7_crc_frozen: assert property (@(posedge clk) disable iff (rst)
      in_tail |=> $stable(crc_q[ch]));
  end
endmodule

// File: rtl/aes3_cell.sv
module aes3_cell import aes3_pkg::*; #(
  parameter int SAMPLE_W = 24,
  parameter int HALVES   = 2 * (SAMPLE_W + 8),
  parameter int HC_W     = $clog2(HALVES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [HC_W-1:0]     hc,
  input  pre_kind_e           kind,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                v_bit,
  input  logic                u_bit,
  input  logic                c_bit,
  output logic                line_q,
  output logic                line_n_q,
  output logic                ack_q
);
  localparam int PAY_W      = SAMPLE_W + 4;
  localparam int PRE_HALVES = 8;

  logic [PAY_W-1:0] sh_q, payload;
  logic             base_q, emit_q, par, base, nxt;
  logic [HC_W-1:0]  hc_e_q;
  logic [7:0]       pat;

  always_comb begin
    par     = ^{c_bit, u_bit, v_bit, sample};
    payload = {par, c_bit, u_bit, v_bit, sample};
    base    = (hc == '0) ? line_q : base_q;
    case (kind)
      PRE_KIND_Z: pat = PRE_Z;
      PRE_KIND_Y: pat = PRE_Y;
      default:    pat = PRE_X;
    endcase
    if (hc < HC_W'(PRE_HALVES)) nxt = base ^ pat[3'd7 - hc[2:0]];
    else if (!hc[0])            nxt = ~line_q;
    else                        nxt = line_q ^ sh_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= 1'b0;
      line_n_q <= 1'b0;
      base_q   <= 1'b0;
      sh_q     <= '0;
      ack_q    <= 1'b0;
      emit_q   <= 1'b0;
      hc_e_q   <= '0;
    end else begin
      line_q   <= nxt;
      line_n_q <= ~nxt;
      ack_q    <= load;
      emit_q   <= 1'b1;
      hc_e_q   <= hc;
      if (load) begin
        sh_q   <= payload;
        base_q <= line_q;
      end else if (hc >= HC_W'(PRE_HALVES) && hc[0]) begin
        sh_q <= sh_q >> 1;
      end
    end
  end

  // R3: every data slot begins with a transition
  a_r3_slot_edge: assert property (@(posedge clk) disable iff (rst)
    (emit_q && hc_e_q >= HC_W'(PRE_HALVES) && !hc_e_q[0]) |-> line_q != $past(line_q));

  // R2: even parity returns the line to its level before the preamble
  a_r2_parity_level: assert property (@(posedge clk) disable iff (rst)
    (emit_q && hc_e_q == HC_W'(HALVES - 1)) |-> line_q == base_q);
endmodule

// File: rtl/aes3_tx.sv
module aes3_tx import aes3_pkg::*; #(
  parameter int SAMPLE_W     = 24,
  parameter int FRAMES       = 192,
  parameter int STROBE_FRAME = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                smp_v,
  input  logic                smp_u,
  input  logic                smp_c,
  input  logic                smp_rdy,
  input  logic                pro_mode,
  input  logic                crc_en,
  output logic                smp_ack,
  output logic                tx_p,
  output logic                tx_n,
  output logic                blk_strobe
);
  localparam int HALVES = 2 * (SAMPLE_W + 8);
  localparam int HC_W   = $clog2(HALVES);
  localparam int FR_W   = $clog2(FRAMES);

  logic [HC_W-1:0]     hc;
  logic                sub, load, crc_bit, in_tail, c_raw, c_eff, v_eff, u_eff;
  logic [FR_W-1:0]     frm;
  logic [SAMPLE_W-1:0] s_eff;
  pre_kind_e           kind;

  aes3_timing #(.FRAMES(FRAMES), .HALVES(HALVES), .STROBE_FRAME(STROBE_FRAME),
                .HC_W(HC_W), .FR_W(FR_W)) u_timing (
    .clk(clk), .rst(rst), .hc(hc), .sub(sub), .frm(frm), .blk_q(blk_strobe));

  always_comb begin
    load  = (hc == '0);
    s_eff = smp_rdy ? smp_data : '0;
    v_eff = smp_rdy ? smp_v : 1'b1;
    u_eff = smp_rdy & smp_u;
    c_raw = smp_rdy & smp_c;
    c_eff = (pro_mode && crc_en && in_tail) ? crc_bit : c_raw;
    if (sub)            kind = PRE_KIND_Y;
    else if (frm == '0) kind = PRE_KIND_Z;
    else                kind = PRE_KIND_X;
  end

  aes3_crc #(.FRAMES(FRAMES), .FR_W(FR_W)) u_crc (
    .clk(clk), .rst(rst), .load(load), .sub(sub), .frm(frm), .c_in(c_eff),
    .crc_bit(crc_bit), .in_tail(in_tail));

  aes3_cell #(.SAMPLE_W(SAMPLE_W), .HALVES(HALVES), .HC_W(HC_W)) u_cell (
    .clk(clk), .rst(rst), .load(load), .hc(hc), .kind(kind), .sample(s_eff),
    .v_bit(v_eff), .u_bit(u_eff), .c_bit(c_eff),
    .line_q(tx_p), .line_n_q(tx_n), .ack_q(smp_ack));

  // R6: acknowledge appears only in the clock after the capture edge
  a_r6_ack_slot: assert property (@(posedge clk) disable iff (rst)
    smp_ack |-> hc == HC_W'(1));
endmodule

// File: tb/aes3_tx_test.sv
module aes3_tx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] smp_data = '0;
  logic smp_v = 1'b0, smp_u = 1'b0, smp_c = 1'b0, smp_rdy = 1'b0;
  logic pro_mode = 1'b0, crc_en = 1'b0;
  logic smp_ack, tx_p, tx_n, blk_strobe;

  always #2.5 clk = ~clk;  // 200 MHz

  aes3_tx uut (.clk(clk), .rst(rst), .smp_data(smp_data), .smp_v(smp_v),
    .smp_u(smp_u), .smp_c(smp_c), .smp_rdy(smp_rdy), .pro_mode(pro_mode),
    .crc_en(crc_en), .smp_ack(smp_ack), .tx_p(tx_p), .tx_n(tx_n),
    .blk_strobe(blk_strobe));

  int total = 0, bad = 0;
  int eq_v[$];
  int eq_t[$];
  logic mlvl = 1'b0;
  logic [7:0] mcrc [2];
  int mfrm = 0, msub = 0, blkn = 0;
  logic [23:0] lfsr = 24'h5A3C91;
  logic rst_seen = 1'b1;
  int p = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input int tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d at pos %0d: actual=%0d expected=%0d", tag, p, act, exp);
    end
  endtask

  function automatic logic [7:0] step(input logic [7:0] r, input logic d);
    logic fb;
    fb = d ^ r[7];
    return {r[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
  endfunction

  // driver: applies inputs for the next subframe and pushes its expected half-cells
  task automatic next_sub(input int n);
    logic [23:0] d;
    logic v, u, c, rdy, par;
    logic [27:0] bits;
    logic [7:0] pre;
    int pre_tag, c_tag, dat_tag;
    lfsr = {lfsr[22:0], lfsr[23] ^ lfsr[22] ^ lfsr[21] ^ lfsr[16]};
    case (n % 11)
      3: d = 24'hFFFFFF;
      6: d = 24'h000000;
      9: d = 24'hAAAAAA;
      default: d = lfsr;
    endcase
    v = lfsr[3]; u = lfsr[7]; c = lfsr[11];
    rdy = (n % 37) != 5;
    if (mfrm == 0 && msub == 0) begin
      pro_mode = (blkn % 3) != 1;   // block 0: pro+crc, 1: consumer (R8), 2: crc off (R8)
      crc_en   = (blkn % 3) != 2;
      blkn++;
    end
    smp_data = d; smp_v = v; smp_u = u; smp_c = c; smp_rdy = rdy;
    dat_tag = 2;                                   // R2
    if (!rdy) begin d = '0; v = 1'b1; u = 1'b0; c = 1'b0; dat_tag = 6; end  // R6
    c_tag = dat_tag;
    if (mfrm >= 184) begin
      if (pro_mode && crc_en) begin c = mcrc[msub][mfrm-184]; c_tag = 7; end  // R7
      else c_tag = 8;                                                         // R8
    end else begin
      mcrc[msub] = step((mfrm == 0) ? 8'hFF : mcrc[msub], c);
    end
    par = ^{c, u, v, d};
    bits = {par, c, u, v, d};
    if (msub == 1) begin pre = 8'b11100100; pre_tag = 4; end       // R4 Y
    else if (mfrm == 0) begin pre = 8'b11101000; pre_tag = 5; end  // R5 Z
    else begin pre = 8'b11100010; pre_tag = 4; end                 // R4 X
    for (int i = 0; i < 8; i++) begin
      eq_v.push_back(int'(mlvl ^ pre[7-i])); eq_t.push_back(pre_tag);
    end
    mlvl = mlvl ^ pre[0];
    for (int s = 0; s < 28; s++) begin
      mlvl = ~mlvl;
      eq_v.push_back(int'(mlvl)); eq_t.push_back(3);               // R3 cell start
      mlvl = mlvl ^ bits[s];
      eq_v.push_back(int'(mlvl));
      eq_t.push_back((s == 26) ? c_tag : (s == 24 || s == 27) ? ((s == 24) ? dat_tag : 2) : dat_tag);
    end
    if (msub == 1) mfrm = (mfrm == 191) ? 0 : mfrm + 1;
    msub = 1 - msub;
  endtask

  task automatic wait_ack();
    do @(negedge clk); while (!smp_ack);
  endtask

  always @(posedge clk) rst_seen <= rst;

  // monitor: pops expected half-cells and compares at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      if (rst_seen) begin
        check(!tx_p && !tx_n && !blk_strobe && !smp_ack, 1,
              {tx_p, tx_n, blk_strobe, smp_ack}, 0);  // R1
        p = 0;
      end else begin
        if (eq_v.size() > 0) begin
          int ev, et;
          ev = eq_v.pop_front(); et = eq_t.pop_front();
          check(int'(tx_p) == ev, et, tx_p, ev);
          check(tx_n == ~tx_p, 10, tx_n, !tx_p);                   // R10
        end
        check(blk_strobe == (((p + 2) % 24576) < 16384), 9, blk_strobe,
              (((p + 2) % 24576) < 16384));                       // R9
        check(smp_ack == ((p % 64) == 0), 6, smp_ack, ((p % 64) == 0));  // R6
        p++;
      end
    end
  end

  initial begin
    next_sub(0);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    for (int n = 1; n < 384 * 2 + 40; n++) begin
      wait_ack();
      next_sub(n);
    end
    // mid-frame reset, then restart from Z at level 0 (R1, R5)
    repeat (20) @(posedge clk);
    #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    eq_v.delete(); eq_t.delete();
    mlvl = 1'b0; mfrm = 0; msub = 0; blkn = 0;
    next_sub(1000);
    @(posedge clk);
    #1 rst = 1'b0;
    for (int n = 1001; n < 1013; n++) begin
      wait_ack();
      next_sub(n);
    end
    repeat (70) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule